// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches the running calendar and raises a flag when the time reaches a programmed instant. Four alarm registers hold a minute, an hour, a day of the month and a day of the week. The minute, hour and day values are in BCD. The weekday value is a plain binary number. Bit 7 of each register is an active-low enable. A field takes part in the comparison only while that bit is 0. By enabling different subsets of fields, the alarm can repeat hourly, daily, monthly or weekly, or at any combination of these.

The surrounding clock logic presents the current time fields and pulses a one-cycle update strobe whenever those fields advance. The comparison is made only on that strobe. The flag is set on the strobe at which the enabled fields go from not matching to matching. It stays set until software clears it. An interrupt request line, active low, mirrors the flag while the interrupt enable is high.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After reset `alarm_flag` is 0, `irq_n` is 1, and all four alarm registers read as disabled (bit 7 = 1). An update strobe with any time therefore leaves the flag at 0.
- R2: When an update strobe arrives and every enabled field equals the current time, `alarm_flag` reads 1 from the first clock edge after the strobe.
- R3: A field whose register has bit 7 = 1 is left out of the comparison, so a mismatch in that field does not block the flag.
- R4: With several fields enabled, the flag sets only when all of them match on the same strobe. A mismatch in any one of them, including the weekday, keeps it at 0.
- R5: Once set, the flag stays 1 across later strobes and cycles, whether or not the time matches, until `flag_clr` is pulsed.
- R6: A `flag_clr` pulse with no competing set clears the flag at the next edge. If the match still holds at the following strobe, the flag stays 0.
- R7: After a clear, the flag sets again only at a strobe where the match is present and the previous strobe had no match.
- R8: If `flag_clr` and a setting strobe occur in the same cycle, the flag ends up set.
- R9: With bit 7 = 1 in all four registers, the flag never sets.
- R10: `irq_n` is 0 exactly when `alarm_flag` is 1 and `irq_en` is 1. Otherwise it is 1.
- R11: Only the low bits of each field are compared: 7 bits for the minute, 6 for the hour, 6 for the day and 3 for the weekday. Higher bits of both the time inputs and the alarm values are ignored.
- R12: Without an update strobe the flag does not set, even while the enabled fields equal the time.
- R13: A write with `wr_en` = 1 loads `wr_data` into the register chosen by `wr_addr` (0 minute, 1 hour, 2 day, 3 weekday). The write takes effect from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| time_tick | input | 1 | One-cycle strobe: time fields have just advanced |
| cur_min | input | 8 | Current minute, BCD |
| cur_hour | input | 8 | Current hour, BCD |
| cur_day | input | 8 | Current day of month, BCD |
| cur_wday | input | 8 | Current weekday, binary |
| wr_en | input | 1 | Alarm register write strobe |
| wr_addr | input | 2 | Register select: 0 minute, 1 hour, 2 day, 3 weekday |
| wr_data | input | 8 | Bit 7 active-low enable, bits 6:0 value |
| flag_clr | input | 1 | Software clear of the alarm flag |
| irq_en | input | 1 | Interrupt enable |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions assume that `time_tick` is a single-cycle pulse and that the time fields are stable and valid whenever it is high. They also assume `flag_clr` is a software pulse that may coincide with a strobe. The bench drives every input on the falling edge and holds the time fields steady around each strobe. It raises `time_tick` for exactly one cycle at a time. Register writes and clears are kept separate from strobes, except in the deliberate set-versus-clear collision.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;
    localparam int FLD_W  = 8;
    localparam int NUM_F  = 4;
    localparam int ADDR_W = $clog2(NUM_F);

    typedef enum logic [ADDR_W-1:0] {
        F_MIN  = 2'd0,
        F_HOUR = 2'd1,
        F_DAY  = 2'd2,
        F_WDAY = 2'd3
    } fld_sel_e;

    typedef struct packed {
        logic       off;   // active-low enable: 1 = field ignored
        logic [6:0] val;
    } alm_reg_t;

    localparam alm_reg_t ALM_RST = '{off: 1'b1, val: 7'd0};

    typedef logic [NUM_F-1:0][FLD_W-1:0] time_vec_t;

    function automatic logic [FLD_W-1:0] field_mask(input int idx);
        case (idx)
            0:       return 8'h7F;
            1, 2:    return 8'h3F;
            default: return 8'h07;
        endcase
    endfunction

    function automatic logic field_eq(input logic [FLD_W-1:0] a,
                                      input logic [FLD_W-1:0] b,
                                      input logic [FLD_W-1:0] m);
        return ((a ^ b) & m) == '0;
    endfunction
endpackage

// File: rtl/alm_regfile.sv
module alm_regfile
    import rtc_alm_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [FLD_W-1:0]            wr_data,
    output alm_reg_t [NUM_F-1:0]        regs_o
);
    for (genvar i = 0; i < NUM_F; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_o[i] <= ALM_RST;
            else if (wr_en && wr_addr == ADDR_W'(i))
                regs_o[i] <= alm_reg_t'(wr_data);
        end
    end

    // R13
    reg_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(F_MIN)) |=> (regs_o[F_MIN] == $past(wr_data)));
endmodule

// File: rtl/alm_compare.sv
module alm_compare
    import rtc_alm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  alm_reg_t [NUM_F-1:0] regs_i,
    input  time_vec_t            now_i,
    output logic                 hit_o
);
    logic [NUM_F-1:0] fld_ok;
    logic [NUM_F-1:0] fld_off;

    for (genvar i = 0; i < NUM_F; i++) begin : g_cmp
        assign fld_off[i] = regs_i[i].off;
        assign fld_ok[i]  = regs_i[i].off |
                            field_eq({1'b0, regs_i[i].val}, now_i[i], field_mask(i));
    end

    assign hit_o = (~&fld_off) & (&fld_ok);

    // R9
    all_off_chk: assert property (@(posedge clk) disable iff (rst)
        (&fld_off) |-> !hit_o);
endmodule

// File: rtl/alm_flag.sv
module alm_flag (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic hit_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_n_o
);
    logic prev_hit;
    logic set_req;

    assign set_req = tick_i & hit_i & ~prev_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_hit <= 1'b0;
            flag_o   <= 1'b0;
        end else begin
            if (tick_i)
                prev_hit <= hit_i;
            if (set_req)
                flag_o <= 1'b1;
            else if (clr_i)
                flag_o <= 1'b0;
        end
    end

    assign irq_n_o = ~(flag_o & irq_en_i);

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o);
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_i && hit_i && !prev_hit) |=> flag_o);
    // R12
    no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!flag_o && !tick_i) |=> !flag_o);
    // R6
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !tick_i) |=> !flag_o);
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_alm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       time_tick,
    input  logic [7:0] cur_min,
    input  logic [7:0] cur_hour,
    input  logic [7:0] cur_day,
    input  logic [7:0] cur_wday,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       flag_clr,
    input  logic       irq_en,
    output logic       alarm_flag,
    output logic       irq_n
);
    alm_reg_t [NUM_F-1:0] regs;
    time_vec_t            now;
    logic                 hit;

    assign now[F_MIN]  = cur_min;
    assign now[F_HOUR] = cur_hour;
    assign now[F_DAY]  = cur_day;
    assign now[F_WDAY] = cur_wday;

    alm_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .regs_o (regs)
    );

    alm_compare u_cmp (
        .clk   (clk),
        .rst   (rst),
        .regs_i(regs),
        .now_i (now),
        .hit_o (hit)
    );

    alm_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (time_tick),
        .hit_i   (hit),
        .clr_i   (flag_clr),
        .irq_en_i(irq_en),
        .flag_o  (alarm_flag),
        .irq_n_o (irq_n)
    );

    // R10
    irq_path_chk: assert property (@(posedge clk) disable iff (rst)
        (!alarm_flag) |-> irq_n);
endmodule

// File: tb/rtc_alarm_unit_tb.sv
module rtc_alarm_unit_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       time_tick = 1'b0;
    logic [7:0] cur_min = '0, cur_hour = '0, cur_day = '0, cur_wday = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       flag_clr = 1'b0;
    logic       irq_en = 1'b0;
    logic       alarm_flag, irq_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_alarm_unit u_dut (
        .clk(clk), .rst(rst), .time_tick(time_tick),
        .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day), .cur_wday(cur_wday),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .flag_clr(flag_clr), .irq_en(irq_en),
        .alarm_flag(alarm_flag), .irq_n(irq_n)
    );

    // {min, hour, day, wday, expected flag}; alarm: min 30, hour 12, day/wday off
    localparam int NV = 9;
    localparam logic [32:0] VEC [NV] = '{
        {8'h29, 8'h12, 8'h01, 8'h00, 1'b0},  // R4 minute mismatch
        {8'h30, 8'h12, 8'h01, 8'h00, 1'b1},  // R2 match
        {8'h30, 8'h12, 8'h01, 8'h00, 1'b0},  // R6 held match after clear
        {8'h30, 8'h11, 8'h01, 8'h00, 1'b0},  // R4 hour mismatch
        {8'h30, 8'h12, 8'h01, 8'h00, 1'b1},  // R7 re-arm
        {8'h31, 8'h12, 8'h01, 8'h00, 1'b0},  // R4
        {8'h30, 8'h12, 8'h15, 8'h05, 1'b1},  // R3 disabled fields differ
        {8'h31, 8'h12, 8'h01, 8'h00, 1'b0},  // R4
        {8'hB0, 8'h52, 8'h01, 8'h00, 1'b1}   // R11 upper bits ignored
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_tick(input logic [7:0] m, input logic [7:0] h,
                           input logic [7:0] d, input logic [7:0] w);
        @(negedge clk);
        cur_min = m; cur_hour = h; cur_day = d; cur_wday = w;
        time_tick = 1'b1;
        @(negedge clk);
        time_tick = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 flag", alarm_flag, 1'b0);
        check("R1 irq_n", irq_n, 1'b1);
        // R1 / R9 all fields disabled, time equals register values
        do_tick(8'h00, 8'h00, 8'h00, 8'h00);
        check("R9 all disabled", alarm_flag, 1'b0);

        // R13 program minute and hour, disable day and weekday explicitly
        write_reg(2'd0, 8'h30);
        write_reg(2'd1, 8'h12);
        write_reg(2'd2, 8'h81);
        write_reg(2'd3, 8'h85);
        for (int i = 0; i < NV; i++) begin
            do_tick(VEC[i][32:25], VEC[i][24:17], VEC[i][16:9], VEC[i][8:1]);
            check($sformatf("R2/R3/R4/R6/R7/R11 vec %0d", i), alarm_flag, VEC[i][0]);
            pulse_clr();
        end
        check("R6 clear", alarm_flag, 1'b0);

        // R12: no strobe while matching
        do_reset();
        write_reg(2'd0, 8'h05);
        @(negedge clk);
        cur_min = 8'h05; cur_hour = 8'h00; cur_day = 8'h00; cur_wday = 8'h00;
        repeat (5) @(negedge clk);
        check("R12 no tick", alarm_flag, 1'b0);
        do_tick(8'h05, 8'h00, 8'h00, 8'h00);
        check("R2 minute alarm", alarm_flag, 1'b1);
        // R5 sticky across non-matching strobes
        do_tick(8'h06, 8'h00, 8'h00, 8'h00);
        check("R5 sticky 1", alarm_flag, 1'b1);
        do_tick(8'h07, 8'h00, 8'h00, 8'h00);
        check("R5 sticky 2", alarm_flag, 1'b1);
        // R10 interrupt gating
        @(negedge clk);
        irq_en = 1'b0; #1;
        check("R10 irq masked", irq_n, 1'b1);
        irq_en = 1'b1; #1;
        check("R10 irq active", irq_n, 1'b0);
        pulse_clr();
        #1;
        check("R10 irq after clear", irq_n, 1'b1);

        // R8 clear and set in the same cycle
        @(negedge clk);
        cur_min = 8'h05; time_tick = 1'b1; flag_clr = 1'b1;
        @(negedge clk);
        time_tick = 1'b0; flag_clr = 1'b0;
        check("R8 set wins", alarm_flag, 1'b1);
        pulse_clr();

        // R4 all four fields enabled, weekday decides
        write_reg(2'd1, 8'h08);
        write_reg(2'd2, 8'h21);
        write_reg(2'd3, 8'h03);
        do_tick(8'h05, 8'h08, 8'h21, 8'h04);
        check("R4 weekday mismatch", alarm_flag, 1'b0);
        do_tick(8'h05, 8'h08, 8'h21, 8'h03);
        check("R4 all match", alarm_flag, 1'b1);
        irq_en = 1'b0;

        // R9 disable all four again after reset
        do_reset();
        do_tick(8'h05, 8'h08, 8'h21, 8'h03);
        check("R1 registers disabled after reset", alarm_flag, 1'b0);
        finish_run();
    end
endmodule